// File: doc/BRIEF.md
# Age-Ordered Ready Micro-Op Selector

This block is the select stage of a reservation station that serves a single execution port. Micro-ops arrive in program order through an allocate interface and are appended to a queue that is always kept sorted by age. Slot 0 holds the oldest entry. Each entry holds a tag, the port it was bound to before it arrived, and a ready flag. An entry becomes ready either when it is allocated or when the wakeup bit for its slot is set.

In every cycle the block finds the entries that are ready and bound to its own port, and dispatches one of them. It drives the tag on the dispatch outputs and removes the entry at the next clock edge. All younger entries then move down one slot, so age order is never broken. A build-time mode selects between two scan rules. The first always picks the oldest eligible entry. The second is a cheaper scan that starts at a rotating pointer and can pass over the oldest eligible entry.

Top module: `age_queue_sel`

## Requirements
- R1: While reset is asserted and after it is released, the queue is empty, `disp_valid_o` is 0 and `alloc_accept_o` is 1.
- R2: When `alloc_valid_i` and `alloc_accept_o` are both high at a clock edge, the micro-op is appended behind every held entry, so slot index follows program order (slot 0 is the oldest).
- R3: `disp_valid_o` is high in a cycle exactly when some held entry is ready and has a port equal to `PORT_ID`. `disp_tag_o` then carries that entry's tag, and the entry is gone after the next edge.
- R4: In oldest mode (`MODE` = 0), the dispatched entry is the eligible entry with the lowest slot index.
- R5: When `DEPTH` entries are held, `alloc_accept_o` is 0 and an allocate request is dropped, even if a dispatch happens in the same cycle.
- R6: Bit k of `wake_i` marks the entry currently in slot k as ready at the next edge. A wakeup aimed at an empty slot, or at the slot being dispatched, has no effect.
- R7: On a dispatch, every younger entry moves down one slot and keeps its tag, port and ready state. An allocation in the same cycle lands in the first free slot after that move.
- R8: An entry whose port differs from `PORT_ID` is never dispatched, and it keeps its slot and its age.
- R9: In rotating mode (`MODE` = 1), a pointer is 0 after reset and advances by one modulo `DEPTH` on every clock edge. The pick is the lowest eligible slot at or above the pointer, or the lowest eligible slot overall if there is none at or above it.
- R10: A micro-op allocated with `alloc_ready_i` = 1 can be dispatched in the cycle right after its allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocate request |
| alloc_tag_i | input | TAG_W | Tag of the new micro-op |
| alloc_port_i | input | PORT_W | Port the micro-op is bound to |
| alloc_ready_i | input | 1 | Micro-op is ready when allocated |
| alloc_accept_o | output | 1 | Queue can take an entry this cycle |
| wake_i | input | DEPTH | Per-slot wakeup, bit k aims at slot k |
| disp_valid_o | output | 1 | A micro-op is dispatched this cycle |
| disp_tag_o | output | TAG_W | Tag of the dispatched micro-op |

## Verification
The bench builds two copies of the block with `DEPTH` = 8 and `PORT_ID` = 1. One copy uses oldest mode and the other uses rotating mode, and both receive the same stimulus. With eight slots, a full queue, a refused allocation and a full pointer wrap each occur within a few tens of cycles. Running both modes side by side shows the rotating scan skipping an older eligible entry, while the oldest-mode copy must never do so. A small share of micro-ops bound to another port stays in the queue until the next reset. These entries block slots, so the bench also checks a queue that is full of entries that can never be dispatched.

// File: rtl/age_queue_sel_pkg.sv
package age_queue_sel_pkg;
  typedef enum logic {
    SEL_OLDEST = 1'b0,
    SEL_ROTATE = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/age_pick.sv
module age_pick #(
  parameter int unsigned DEPTH  = 16,
  parameter bit          ROTATE = 1'b0,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] elig_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] sel_o
);
  logic [DEPTH-1:0] upper;
  logic [IDX_W-1:0] low_all, low_up;
  logic             any_up;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) upper[i] = elig_i[i] && (IDX_W'(i) >= ptr_i);
  end

  // lowest set index, scanned from the top so the last write wins
  always_comb begin
    low_all = '0;
    low_up  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (elig_i[i]) low_all = IDX_W'(i);
      if (upper[i])  low_up  = IDX_W'(i);
    end
  end

  assign any_up = |upper;
  assign hit_o  = |elig_i;
  assign sel_o  = (ROTATE && any_up) ? low_up : low_all;
endmodule

// File: rtl/age_slot.sv
module age_slot #(
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned PORT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              load_i,
  input  logic              wake_i,
  input  logic              nxt_valid_i,
  input  logic              nxt_rdy_i,
  input  logic              nxt_wake_i,
  input  logic [PORT_W-1:0] nxt_port_i,
  input  logic [TAG_W-1:0]  nxt_tag_i,
  input  logic              new_rdy_i,
  input  logic [PORT_W-1:0] new_port_i,
  input  logic [TAG_W-1:0]  new_tag_i,
  output logic              valid_o,
  output logic              rdy_o,
  output logic [PORT_W-1:0] port_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic              valid_d, rdy_d;
  logic [PORT_W-1:0] port_d;
  logic [TAG_W-1:0]  tag_d;

  always_comb begin
    if (load_i) begin
      valid_d = 1'b1;
      rdy_d   = new_rdy_i;
      port_d  = new_port_i;
      tag_d   = new_tag_i;
    end else if (shift_i) begin
      valid_d = nxt_valid_i;
      rdy_d   = nxt_valid_i && (nxt_rdy_i || nxt_wake_i);
      port_d  = nxt_port_i;
      tag_d   = nxt_tag_i;
    end else begin
      valid_d = valid_o;
      rdy_d   = valid_o && (rdy_o || wake_i);
      port_d  = port_o;
      tag_d   = tag_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      rdy_o   <= 1'b0;
      port_o  <= '0;
      tag_o   <= '0;
    end else begin
      valid_o <= valid_d;
      rdy_o   <= rdy_d;
      port_o  <= port_d;
      tag_o   <= tag_d;
    end
  end
endmodule

// File: rtl/age_queue_sel.sv
module age_queue_sel
  import age_queue_sel_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned TAG_W   = 6,
  parameter int unsigned PORT_W  = 2,
  parameter logic [PORT_W-1:0] PORT_ID = '0,
  parameter sel_mode_e   MODE    = SEL_OLDEST,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [TAG_W-1:0]  alloc_tag_i,
  input  logic [PORT_W-1:0] alloc_port_i,
  input  logic              alloc_ready_i,
  output logic              alloc_accept_o,
  input  logic [DEPTH-1:0]  wake_i,
  output logic              disp_valid_o,
  output logic [TAG_W-1:0]  disp_tag_o
);
  logic [DEPTH-1:0]             valid_q, rdy_q, elig, shift, load;
  logic [DEPTH-1:0][PORT_W-1:0] port_q;
  logic [DEPTH-1:0][TAG_W-1:0]  tag_q;
  logic [CNT_W-1:0]             count_q, base;
  logic [IDX_W-1:0]             sel, ptr_q;
  logic                         hit, alloc_fire;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) elig[i] = valid_q[i] && rdy_q[i] && (port_q[i] == PORT_ID);
  end

  age_pick #(
    .DEPTH (DEPTH),
    .ROTATE(MODE == SEL_ROTATE)
  ) u_pick (
    .elig_i(elig),
    .ptr_i (ptr_q),
    .hit_o (hit),
    .sel_o (sel)
  );

  assign alloc_accept_o = (count_q != CNT_W'(DEPTH));
  assign alloc_fire     = alloc_valid_i && alloc_accept_o;
  assign disp_valid_o   = hit;
  assign disp_tag_o     = tag_q[sel];
  // first free slot once the dispatched entry has been squeezed out
  assign base           = count_q - CNT_W'(hit);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              n_valid, n_rdy, n_wake;
    logic [PORT_W-1:0] n_port;
    logic [TAG_W-1:0]  n_tag;

    assign shift[g] = hit && (IDX_W'(g) >= sel);
    assign load[g]  = alloc_fire && (CNT_W'(g) == base);

    if (g == DEPTH - 1) begin : g_top
      assign n_valid = 1'b0;
      assign n_rdy   = 1'b0;
      assign n_wake  = 1'b0;
      assign n_port  = '0;
      assign n_tag   = '0;
    end else begin : g_mid
      assign n_valid = valid_q[g+1];
      assign n_rdy   = rdy_q[g+1];
      assign n_wake  = wake_i[g+1];
      assign n_port  = port_q[g+1];
      assign n_tag   = tag_q[g+1];
    end

    age_slot #(
      .TAG_W (TAG_W),
      .PORT_W(PORT_W)
    ) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .shift_i    (shift[g]),
      .load_i     (load[g]),
      .wake_i     (wake_i[g]),
      .nxt_valid_i(n_valid),
      .nxt_rdy_i  (n_rdy),
      .nxt_wake_i (n_wake),
      .nxt_port_i (n_port),
      .nxt_tag_i  (n_tag),
      .new_rdy_i  (alloc_ready_i),
      .new_port_i (alloc_port_i),
      .new_tag_i  (alloc_tag_i),
      .valid_o    (valid_q[g]),
      .rdy_o      (rdy_q[g]),
      .port_o     (port_q[g]),
      .tag_o      (tag_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= base + CNT_W'(alloc_fire);
  end

  if (MODE == SEL_ROTATE) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         ptr_q <= '0;
      else if (ptr_q == IDX_W'(DEPTH - 1)) ptr_q <= '0;
      else                                 ptr_q <= ptr_q + 1'b1;
    end
  end else begin : g_no_ptr
    assign ptr_q = '0;
  end
endmodule

// File: rtl/age_queue_sel_chk.sv
module age_queue_sel_chk #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned TAG_W  = 6,
  parameter bit          ROTATE = 1'b0,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [DEPTH-1:0]            valid_q,
  input logic [DEPTH-1:0]            elig,
  input logic [DEPTH-1:0][TAG_W-1:0] tag_q,
  input logic [CNT_W-1:0]            count_q,
  input logic [IDX_W-1:0]            sel,
  input logic [IDX_W-1:0]            ptr_q,
  input logic                        hit,
  input logic                        alloc_valid_i,
  input logic                        alloc_accept_o
);
  logic [DEPTH-1:0] one, below_sel, below_ptr;
  logic [IDX_W:0]   sel_up;
  logic             shift_seen, shift_now;
  logic [IDX_W-1:0] sel_d;
  logic [TAG_W-1:0] yng_d, yng_now;

  assign one       = DEPTH'(1);
  assign below_sel = (one << sel) - one;
  assign below_ptr = (one << ptr_q) - one;
  assign sel_up    = {1'b0, sel} + 1'b1;
  assign shift_now = hit && (int'(sel_up) < int'(count_q));
  assign yng_now   = tag_q[sel_up[IDX_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_seen <= 1'b0;
      sel_d      <= '0;
      yng_d      <= '0;
    end else begin
      shift_seen <= shift_now;
      sel_d      <= sel;
      yng_d      <= yng_now;
    end
  end

  a_r2_valid_packed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q & (valid_q + 1'b1)) == '0);
  a_r5_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_q) <= int'(DEPTH));
  a_r5_refused_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && !alloc_accept_o && !hit) |=> count_q == $past(count_q));
  a_r3_pick_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> elig[sel]);
  a_r7_collapse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_seen |-> tag_q[sel_d] == yng_d);
  a_r9_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ptr_q) < int'(DEPTH));

  if (ROTATE) begin : g_rot
    a_r9_from_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && ((elig & ~below_ptr) != '0)) |-> sel >= ptr_q);
  end else begin : g_old
    a_r4_oldest: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit |-> (elig & below_sel) == '0);
  end
endmodule

bind age_queue_sel age_queue_sel_chk #(
  .DEPTH (DEPTH),
  .TAG_W (TAG_W),
  .ROTATE(MODE == age_queue_sel_pkg::SEL_ROTATE)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .valid_q       (valid_q),
  .elig          (elig),
  .tag_q         (tag_q),
  .count_q       (count_q),
  .sel           (sel),
  .ptr_q         (ptr_q),
  .hit           (hit),
  .alloc_valid_i (alloc_valid_i),
  .alloc_accept_o(alloc_accept_o)
);

// File: tb/age_queue_sel_tb.sv
`timescale 1ns/1ps
module age_queue_sel_tb;
  import age_queue_sel_pkg::*;

  localparam int DEPTH = 8;
  localparam int TAG_W = 8;
  localparam int PORT_W = 2;
  localparam logic [PORT_W-1:0] PID = 2'd1;

  typedef struct {
    logic [TAG_W-1:0]  tag;
    logic [PORT_W-1:0] port;
    bit                rdy;
  } ent_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic alloc_valid = 1'b0;
  logic [TAG_W-1:0] alloc_tag = '0;
  logic [PORT_W-1:0] alloc_port = '0;
  logic alloc_rdy = 1'b0;
  logic [DEPTH-1:0] wake = '0;
  logic dv [2];
  logic da [2];
  logic [TAG_W-1:0] dt [2];

  ent_t q [2][$];
  int ptr [2];
  int checks = 0, failures = 0;
  logic [TAG_W-1:0] next_tag = 8'd1;

  always #5 clk = ~clk;

  age_queue_sel #(.DEPTH(DEPTH), .TAG_W(TAG_W), .PORT_W(PORT_W), .PORT_ID(PID), .MODE(SEL_OLDEST)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .alloc_valid_i(alloc_valid), .alloc_tag_i(alloc_tag),
    .alloc_port_i(alloc_port), .alloc_ready_i(alloc_rdy), .alloc_accept_o(da[0]),
    .wake_i(wake), .disp_valid_o(dv[0]), .disp_tag_o(dt[0]));

  age_queue_sel #(.DEPTH(DEPTH), .TAG_W(TAG_W), .PORT_W(PORT_W), .PORT_ID(PID), .MODE(SEL_ROTATE)) u_dut_rot (
    .clk_i(clk), .rst_ni(rst_ni), .alloc_valid_i(alloc_valid), .alloc_tag_i(alloc_tag),
    .alloc_port_i(alloc_port), .alloc_ready_i(alloc_rdy), .alloc_accept_o(da[1]),
    .wake_i(wake), .disp_valid_o(dv[1]), .disp_tag_o(dt[1]));

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R4 / R9 scan rules of the reference queue
  function automatic int pick(int m);
    int first = -1, up = -1;
    for (int i = 0; i < q[m].size(); i++) begin
      if (q[m][i].rdy && q[m][i].port == PID) begin
        if (first < 0) first = i;
        if (up < 0 && i >= ptr[m]) up = i;
      end
    end
    if (m == 1 && up >= 0) return up;
    return first;
  endfunction

  task automatic tick(string req);
    #1;
    for (int m = 0; m < 2; m++) begin
      int s = pick(m);
      bit acc = (q[m].size() < DEPTH);
      string mr = (m == 0) ? {req, "/oldest"} : {req, "/rotate"};
      chk(dv[m] == (s >= 0), mr, "disp_valid", int'(dv[m]), int'(s >= 0));
      if (s >= 0) chk(dt[m] == q[m][s].tag, mr, "disp_tag", int'(dt[m]), int'(q[m][s].tag));
      chk(da[m] == acc, mr, "alloc_accept", int'(da[m]), int'(acc));
      for (int i = 0; i < q[m].size(); i++) if (wake[i]) q[m][i].rdy = 1'b1;
      if (s >= 0) q[m].delete(s);
      if (alloc_valid && acc) begin
        ent_t e;
        e.tag = alloc_tag; e.port = alloc_port; e.rdy = alloc_rdy;
        q[m].push_back(e);
      end
      ptr[m] = (ptr[m] + 1) % DEPTH;
    end
    @(negedge clk);
  endtask

  task automatic cyc(bit av, logic [PORT_W-1:0] pt, bit rd, logic [DEPTH-1:0] wk, string req);
    alloc_valid = av; alloc_port = pt; alloc_rdy = rd; wake = wk; alloc_tag = next_tag;
    tick(req);
    if (av) next_tag++;
    alloc_valid = 1'b0; wake = '0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    alloc_valid = 1'b0; wake = '0;
    for (int m = 0; m < 2; m++) begin q[m].delete(); ptr[m] = 0; end
    @(negedge clk); #1;
    for (int m = 0; m < 2; m++) begin
      chk(dv[m] == 1'b0, "R1", "disp_valid in reset", int'(dv[m]), 0);
      chk(da[m] == 1'b1, "R1", "alloc_accept in reset", int'(da[m]), 1);
    end
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    cyc(0, PID, 0, '0, "R1");

    // R10: ready at allocation, dispatched the next cycle
    cyc(1, PID, 1, '0, "R10");
    cyc(0, PID, 0, '0, "R10");

    // R2/R4/R9: four waiting entries, younger ones woken first
    for (int i = 0; i < 4; i++) cyc(1, PID, 0, '0, "R2");
    cyc(0, PID, 0, 8'b0000_1010, "R6");
    cyc(0, PID, 0, '0, "R4");
    cyc(0, PID, 0, 8'b0000_0001, "R9");
    for (int i = 0; i < 4; i++) cyc(0, PID, 0, '0, "R4");

    // R6: wakeup on an empty slot is dropped, later occupant stays waiting
    cyc(1, PID, 0, 8'b0000_0010, "R6");
    cyc(1, PID, 0, '0, "R6");
    cyc(0, PID, 0, '0, "R6");
    cyc(0, PID, 0, 8'b0000_0011, "R6");
    cyc(0, PID, 0, '0, "R6");
    cyc(0, PID, 0, '0, "R6");

    // R8: ready entry on a foreign port holds its slot
    cyc(1, 2'd2, 1, '0, "R8");
    cyc(1, PID, 1, '0, "R8");
    cyc(0, PID, 0, 8'b0000_0001, "R8");
    cyc(0, PID, 0, '0, "R8");

    // R5: fill, refused request, dispatch+alloc while full
    do_reset();
    for (int i = 0; i < DEPTH; i++) cyc(1, PID, 0, '0, "R5");
    cyc(1, PID, 1, '0, "R5");
    cyc(1, PID, 1, 8'b0010_0000, "R5");
    // R7: dispatch with allocation landing behind the moved entries
    cyc(1, PID, 0, 8'b0100_0001, "R7");
    cyc(1, PID, 1, 8'b1000_0000, "R7");
    for (int i = 0; i < 12; i++) cyc(0, PID, 0, 8'hFF, "R7");

    // R5: full of foreign-port entries, nothing ever leaves
    do_reset();
    for (int i = 0; i < DEPTH + 2; i++) cyc(1, 2'd0, 1, '1, "R8");
    cyc(1, PID, 1, '1, "R5");

    // mixed traffic
    for (int r = 0; r < 12; r++) begin
      do_reset();
      for (int c = 0; c < 250; c++) begin
        logic [DEPTH-1:0] wk;
        for (int b = 0; b < DEPTH; b++) wk[b] = ($urandom_range(0, 5) == 0);
        cyc($urandom_range(0, 9) < 6,
            ($urandom_range(0, 15) == 0) ? 2'd3 : PID,
            $urandom_range(0, 3) == 0, wk,
            (r % 2 == 0) ? "R3" : "R7");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule